// File: doc/BRIEF.md
# Byte/Word Lane Mover

This unit copies one 8-bit or 16-bit lane from a 32-bit source operand into one lane of a 32-bit destination operand. All other destination bits are kept. A 9-bit configuration register sets four things: the lane size, the lane pointer on each side, and what each pointer does after a move. Because the pointers step by themselves after every move, a series of moves can pack or unpack bytes or half-words across a word with no reconfiguration. One destination mode rotates the destination left by one lane before the insertion. Repeated moves in that mode shift a stream of fields in from the bottom.

A core uses the unit through two operations. A configuration load writes all nine bits. The value comes from a register or from an immediate; at this block's edge the two cases look the same. A move supplies the destination value and either a register source or a 9-bit immediate source, which is zero-extended. The merged destination appears on the output one clock later, together with a done strobe. The pointers advance on that same clock edge. When a load and a move arrive in the same cycle, the load wins and the move is dropped.

Top module: `fmv_top`

## Requirements
- R1: After reset the configuration equals 9'b0_0100_0000. A move then returns the destination rotated left by 8 bits, with the source's low byte in bits 7:0, and the pointers stay where they are.
- R2: The configuration fields sit, from MSB to LSB, as follows: bit 8 is the size flag (1 = 16-bit word lanes, 0 = byte lanes); bits 7:6 are the destination mode; bits 5:4 are the destination pointer; bits 3:2 are the source mode; bits 1:0 are the source pointer.
- R3: In byte mode, pointer value k (0..3) selects bits 8k+7:8k on that side.
- R4: In word mode, pointer values 0 and 1 select bits 15:0, and values 2 and 3 select bits 31:16.
- R5: Destination mode 01 rotates the destination left by one lane width (8 or 16 bits) before the insertion, and leaves the destination pointer unchanged.
- R6: Destination mode 10 increments the destination pointer after a move, and mode 11 decrements it. Mode 00 holds it. The step is 1 in byte mode and 2 in word mode, and the pointer wraps modulo 4.
- R7: Source mode 10 increments the source pointer after a move, and mode 11 decrements it. Both modes 00 and 01 hold it. The step size and the wrap are the same as in R6.
- R8: Destination bits outside the selected lane keep their value, taken after any rotation.
- R9: When move_use_imm is 1, the source is move_imm zero-extended to 32 bits, and move_src is ignored.
- R10: A move accepted in cycle N drives move_result and raises move_done in cycle N+1. move_done is 0 in a cycle after no accepted move, and it is 0 after reset.
- R11: A configuration load in the same cycle as a move takes priority. The new value is stored exactly as loaded, the move produces no done strobe, and the move does not step the pointers.
- R12: The configuration and pointers change only through a load or an accepted move. Idle cycles leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load the configuration from cfg_value |
| cfg_value | input | 9 | New configuration (register or immediate) |
| move_en | input | 1 | Request a lane move |
| move_use_imm | input | 1 | Use move_imm as the source instead of move_src |
| move_imm | input | 9 | Immediate source, zero-extended |
| move_src | input | 32 | Register source operand |
| move_dst | input | 32 | Current destination value |
| move_result | output | 32 | Merged destination, valid when move_done is 1 |
| move_done | output | 1 | One-cycle strobe, one clock after an accepted move |

## Verification
Four properties are checked on every cycle: the reset configuration value, load priority with the exact stored value, the done strobe timing, and that the configuration stays unchanged on idle cycles. Two pointer-step rules are also checked every cycle: the word-mode increment of the destination pointer, and the hold of the source pointer. Lane extraction, the rotation, the preservation of the other bits and the wrap behaviour are visible only in the values moves return. The bench's random and directed sequences compare those values against a reference model of the configuration and pointers.

// File: rtl/fmv_pkg.sv
package fmv_pkg;

    localparam int DATA_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int N_BYTES  = DATA_W / BYTE_W;
    localparam int WORD_W   = 2 * BYTE_W;
    localparam int N_WORDS  = DATA_W / WORD_W;
    localparam int PTR_W    = 2;
    localparam int CFG_W    = 9;
    localparam int IMM_W    = 9;

    typedef enum logic [1:0] {
        DM_HOLD   = 2'b00,
        DM_ROTATE = 2'b01,
        DM_INC    = 2'b10,
        DM_DEC    = 2'b11
    } dst_mode_e;

    typedef struct packed {
        logic             wide;
        dst_mode_e        dmode;
        logic [PTR_W-1:0] dptr;
        logic [1:0]       smode;
        logic [PTR_W-1:0] sptr;
    } fmv_cfg_t;

    localparam logic [CFG_W-1:0] CFG_RESET = 9'b0_0100_0000;

    // Post-move pointer update: bit1 of mode enables stepping, bit0 picks direction.
    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p,
                                                  input logic [1:0] mode,
                                                  input logic wide);
        logic [PTR_W-1:0] amt;
        amt = wide ? 2'd2 : 2'd1;
        if (mode[1]) begin
            step_ptr = mode[0] ? (p - amt) : (p + amt);
        end else begin
            step_ptr = p;
        end
    endfunction

endpackage

// File: rtl/fmv_cfg_reg.sv
module fmv_cfg_reg
    import fmv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CFG_W-1:0] load_val,
    input  logic             step,
    output fmv_cfg_t         cfg
);
    fmv_cfg_t cfg_q;
    fmv_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            cfg_d = fmv_cfg_t'(load_val);
        end else if (step) begin
            cfg_d.dptr = step_ptr(cfg_q.dptr, cfg_q.dmode, cfg_q.wide);
            cfg_d.sptr = step_ptr(cfg_q.sptr, cfg_q.smode, cfg_q.wide);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= fmv_cfg_t'(CFG_RESET);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/fmv_extract.sv
module fmv_extract
    import fmv_pkg::*;
(
    input  logic [DATA_W-1:0] src,
    input  logic              wide,
    input  logic [PTR_W-1:0]  ptr,
    output logic [WORD_W-1:0] field
);
    logic [BYTE_W-1:0] byte_lane [N_BYTES];
    logic [WORD_W-1:0] word_lane [N_WORDS];

    for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
        assign byte_lane[b] = src[b*BYTE_W +: BYTE_W];
    end
    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        assign word_lane[w] = src[w*WORD_W +: WORD_W];
    end

    always_comb begin
        if (wide) begin
            field = word_lane[ptr[1]];
        end else begin
            field = {{(WORD_W-BYTE_W){1'b0}}, byte_lane[ptr]};
        end
    end
endmodule

// File: rtl/fmv_insert.sv
module fmv_insert
    import fmv_pkg::*;
(
    input  logic [DATA_W-1:0] dst,
    input  logic [WORD_W-1:0] field,
    input  logic              wide,
    input  logic              rotate,
    input  logic [PTR_W-1:0]  ptr,
    output logic [DATA_W-1:0] merged
);
    logic [DATA_W-1:0] rot_byte;
    logic [DATA_W-1:0] rot_word;
    logic [DATA_W-1:0] base;

    assign rot_byte = {dst[DATA_W-BYTE_W-1:0], dst[DATA_W-1 -: BYTE_W]};
    assign rot_word = {dst[DATA_W-WORD_W-1:0], dst[DATA_W-1 -: WORD_W]};
    assign base     = !rotate ? dst : (wide ? rot_word : rot_byte);

    for (genvar b = 0; b < N_BYTES; b++) begin : g_lane
        localparam logic [PTR_W-1:0] LANE_IDX = PTR_W'(b);
        localparam int               HALF     = b % 2;
        logic hit;
        assign hit = wide ? (LANE_IDX[1] == ptr[1]) : (LANE_IDX == ptr);
        always_comb begin
            if (!hit) begin
                merged[b*BYTE_W +: BYTE_W] = base[b*BYTE_W +: BYTE_W];
            end else if (wide) begin
                merged[b*BYTE_W +: BYTE_W] = field[HALF*BYTE_W +: BYTE_W];
            end else begin
                merged[b*BYTE_W +: BYTE_W] = field[BYTE_W-1:0];
            end
        end
    end
endmodule

// File: rtl/fmv_top.sv
module fmv_top
    import fmv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [CFG_W-1:0]  cfg_value,
    input  logic              move_en,
    input  logic              move_use_imm,
    input  logic [IMM_W-1:0]  move_imm,
    input  logic [DATA_W-1:0] move_src,
    input  logic [DATA_W-1:0] move_dst,
    output logic [DATA_W-1:0] move_result,
    output logic              move_done
);
    fmv_cfg_t          cfg_q;
    logic [CFG_W-1:0]  cfg_bits;
    logic              move_acc;
    logic [DATA_W-1:0] src_sel;
    logic [WORD_W-1:0] field;
    logic [DATA_W-1:0] merged;

    assign move_acc = move_en && !cfg_load;
    assign src_sel  = move_use_imm ? {{(DATA_W-IMM_W){1'b0}}, move_imm} : move_src;
    assign cfg_bits = cfg_q;

    fmv_cfg_reg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .load     (cfg_load),
        .load_val (cfg_value),
        .step     (move_acc),
        .cfg      (cfg_q)
    );

    fmv_extract u_ext (
        .src   (src_sel),
        .wide  (cfg_q.wide),
        .ptr   (cfg_q.sptr),
        .field (field)
    );

    fmv_insert u_ins (
        .dst    (move_dst),
        .field  (field),
        .wide   (cfg_q.wide),
        .rotate (cfg_q.dmode == DM_ROTATE),
        .ptr    (cfg_q.dptr),
        .merged (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            move_done   <= 1'b0;
            move_result <= '0;
        end else begin
            move_done <= move_acc;
            if (move_acc) begin
                move_result <= merged;
            end
        end
    end
endmodule

// File: rtl/fmv_chk.sv
module fmv_chk
    import fmv_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_load,
    input logic [CFG_W-1:0] cfg_value,
    input logic             move_en,
    input logic             move_done,
    input logic [CFG_W-1:0] cfg_bits
);
    // R1
    reset_cfg_chk: assert property (@(posedge clk)
        rst |=> cfg_bits == CFG_RESET);

    // R10
    done_follows_move_chk: assert property (@(posedge clk) disable iff (rst)
        (move_en && !cfg_load) |=> move_done);

    // R11
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> (!move_done && cfg_bits == $past(cfg_value)));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_load && !move_en) |=> ($stable(cfg_bits) && !move_done));

    // R6
    word_dinc_chk: assert property (@(posedge clk) disable iff (rst)
        (move_en && !cfg_load && cfg_bits[8] && cfg_bits[7:6] == 2'b10)
        |=> cfg_bits[5:4] == $past(cfg_bits[5:4]) + 2'd2);

    // R7
    src_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (move_en && !cfg_load && !cfg_bits[3])
        |=> cfg_bits[1:0] == $past(cfg_bits[1:0]));
endmodule

bind fmv_top fmv_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_load  (cfg_load),
    .cfg_value (cfg_value),
    .move_en   (move_en),
    .move_done (move_done),
    .cfg_bits  (cfg_bits)
);

// File: tb/fmv_top_tb.sv
module fmv_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load = 1'b0;
    logic [8:0]  cfg_value = '0;
    logic        move_en = 1'b0;
    logic        move_use_imm = 1'b0;
    logic [8:0]  move_imm = '0;
    logic [31:0] move_src = '0;
    logic [31:0] move_dst = '0;
    logic [31:0] move_result;
    logic        move_done;

    int n_vec = 0;
    int n_bad = 0;
    logic [8:0] mcfg;

    always #2.5 clk = ~clk;

    fmv_top u_dut (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_value(cfg_value),
        .move_en(move_en), .move_use_imm(move_use_imm), .move_imm(move_imm),
        .move_src(move_src), .move_dst(move_dst),
        .move_result(move_result), .move_done(move_done)
    );

    function automatic logic [31:0] ref_move(input logic [8:0] c,
                                             input logic [31:0] s,
                                             input logic [31:0] d);
        logic [5:0]  fw;
        logic [31:0] mask, fld, dd;
        logic [4:0]  shs, shd;
        fw   = c[8] ? 6'd16 : 6'd8;
        mask = c[8] ? 32'h0000_FFFF : 32'h0000_00FF;
        shs  = c[8] ? {c[1], 4'b0} : {c[1:0], 3'b0};
        shd  = c[8] ? {c[5], 4'b0} : {c[5:4], 3'b0};
        fld  = (s >> shs) & mask;
        dd   = d;
        if (c[7:6] == 2'b01) dd = (d << fw) | (d >> (6'd32 - fw));
        return (dd & ~(mask << shd)) | (fld << shd);
    endfunction

    function automatic logic [1:0] ref_step(input logic [1:0] p,
                                            input logic [1:0] m,
                                            input logic w);
        int a;
        a = w ? 2 : 1;
        if (m == 2'b10) return 2'((int'(p) + a) % 4);
        if (m == 2'b11) return 2'((int'(p) + 4 - a) % 4);
        return p;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Called at a negative edge; leaves at the next negative edge.
    task automatic op(input bit ld, input logic [8:0] val, input bit mv,
                      input bit ui, input logic [8:0] imm,
                      input logic [31:0] s, input logic [31:0] d, input string tag);
        logic [31:0] exp, eff_s;
        cfg_load = ld; cfg_value = val; move_en = mv;
        move_use_imm = ui; move_imm = imm; move_src = s; move_dst = d;
        eff_s = ui ? {23'b0, imm} : s;
        exp = ref_move(mcfg, eff_s, d);
        @(posedge clk); #1;
        if (ld) begin
            check(move_done == 1'b0, {tag, " done"}, {31'b0, move_done}, 32'h0);
            mcfg = val;
        end else if (mv) begin
            check(move_done && move_result == exp, tag, move_result, exp);
            mcfg[5:4] = ref_step(mcfg[5:4], mcfg[7:6], mcfg[8]);
            mcfg[1:0] = ref_step(mcfg[1:0], mcfg[3:2], mcfg[8]);
        end else begin
            check(move_done == 1'b0, {tag, " idle"}, {31'b0, move_done}, 32'h0);
        end
        @(negedge clk);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        mcfg = 9'b0_0100_0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(move_done == 1'b0, "R10 reset done", {31'b0, move_done}, 32'h0);
        // R1 reset default: rotate by 8, low byte in
        op(0, 0, 1, 0, 0, 32'h0000_00AB, 32'h1122_3344, "R1 default");
        check(move_result == 32'h2233_44AB, "R1 literal", move_result, 32'h2233_44AB);
        op(0, 0, 1, 0, 0, 32'h0000_00CD, 32'h1122_3344, "R1 pointers hold");
        // R2/R3 byte lanes, both pointers incrementing from dptr0/sptr1
        op(1, 9'b0_10_00_10_01, 0, 0, 0, 0, 0, "R2 load");
        for (int i = 0; i < 5; i++)
            op(0, 0, 1, 0, 0, 32'h4433_2211, 32'hFFFF_FFFF, "R3 byte inc walk");
        // R6 decrement wrap from 0 to 3, byte
        op(1, 9'b0_11_00_11_00, 0, 0, 0, 0, 0, "R2 load");
        for (int i = 0; i < 5; i++)
            op(0, 0, 1, 0, 0, 32'hA1B2_C3D4, 32'h0, "R6 byte dec wrap");
        // R4 word mode, ptr 1 selects low word, inc by 2
        op(1, 9'b1_10_01_11_01, 0, 0, 0, 0, 0, "R2 load");
        for (int i = 0; i < 4; i++)
            op(0, 0, 1, 0, 0, 32'hBEEF_CAFE, 32'h1234_5678, "R4 word step");
        // R5 rotate in word mode
        op(1, 9'b1_01_00_00_10, 0, 0, 0, 0, 0, "R2 load");
        op(0, 0, 1, 0, 0, 32'hBEEF_CAFE, 32'h1234_5678, "R5 word rotate");
        check(move_result == 32'h5678_BEEF, "R5 literal", move_result, 32'h5678_BEEF);
        // R8 byte lane 2 insert keeps others
        op(1, 9'b0_00_10_00_00, 0, 0, 0, 0, 0, "R2 load");
        op(0, 0, 1, 0, 0, 32'h0000_005A, 32'h1122_3344, "R8 keep bits");
        check(move_result == 32'h115A_3344, "R8 literal", move_result, 32'h115A_3344);
        // R9 immediate zero-extended, byte1 of 0x1FF is 0x01
        op(1, 9'b0_00_00_00_01, 0, 0, 0, 0, 0, "R2 load");
        op(0, 0, 1, 1, 9'h1FF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9 imm");
        check(move_result == 32'hFFFF_FF01, "R9 literal", move_result, 32'hFFFF_FF01);
        // R11 load and move together: load wins, new pointers untouched
        op(1, 9'b0_10_01_10_10, 1, 0, 0, 32'h1, 32'h2, "R11 collide");
        op(0, 0, 1, 0, 0, 32'h4433_2211, 32'h0, "R11 after collide");
        check(move_result == 32'h0000_3300, "R11 literal", move_result, 32'h0000_3300);
        // R12 idle cycles leave pointers
        op(0, 0, 0, 0, 0, 0, 0, "R12");
        op(0, 0, 0, 0, 0, 0, 0, "R12");
        op(0, 0, 1, 0, 0, 32'h4433_2211, 32'h0, "R12 after idle");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 9));
            op(r == 0, 9'($urandom), r >= 2, 1'($urandom), 9'($urandom),
               $urandom, $urandom, "R8 random mix");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule